// File: doc/BRIEF.md
# DMA Channel Address and Count Engine

This block is the per-channel address and counter datapath of a four-channel DMA controller. Each channel keeps a source address, a destination address, a transfer counter, a control word and an error flag. Software loads these through a single-cycle write port that selects a channel and a register. A separate strobe stands in for a scatter/gather descriptor fetch and loads a new destination address into a channel that is in scatter/gather mode.

Each time the surrounding controller reports a completed data beat on a channel, the engine advances that channel's addresses by the transfer width and counts the counter down. The addresses move up or down depending on the control bits and the transfer direction. A channel whose active address is not aligned to its transfer width is flagged in error and performs no transfers until software clears the flag. The counter either ends the transfer itself, with a one-cycle terminal-count pulse, or keeps running past zero while it waits for an external end-of-transfer input.

Top module: `dma_addr_engine`

## Requirements
- R1: After reset, every address, counter, control word, error flag and terminal-count pulse is zero, so every channel is disabled.
- R2: A write with `wr_en` high updates the register of channel `wr_chan` that `wr_sel` picks, on the next clock edge: 0 control, 1 source address, 2 destination address, 3 counter (low CNT_W bits), 4 status. The control word fields are: bit 0 enable, bits 2:1 width (0 byte, 1 halfword, 2 or 3 word), bits 4:3 direction (0 memory-to-memory, 1 memory-to-peripheral, 2 peripheral-to-memory, 3 treated as memory-to-memory), bit 5 source increment, bit 6 destination increment, bit 7 decrement, bit 8 external end-of-transfer input mode, bit 9 scatter/gather.
- R3: An enabled channel whose source (memory-to-memory and memory-to-peripheral) or destination (memory-to-memory and peripheral-to-memory) address is misaligned sets its error flag on the next edge: a halfword needs bit 0 clear, a word needs bits 1:0 clear. A beat seen while misaligned changes nothing.
- R4: While its error flag is set, a channel ignores beats. The flag is cleared only by a status write with data bit 0 set; a status write with bit 0 clear leaves it set.
- R5: On an accepted beat, an address that the direction uses and whose increment bit is set grows by the width in bytes (1, 2 or 4); an address the direction does not use is left unchanged.
- R6: With the decrement bit set, the destination address drops by the width only in peripheral-to-memory transfers and the source address only in memory-to-peripheral transfers; in memory-to-memory transfers the decrement bit has no effect.
- R7: In terminal-count mode (bit 8 clear), each accepted beat lowers the counter by one; the beat that takes it from 1 to 0 raises `tc_pulse` for exactly one cycle and clears the channel's enable bit.
- R8: In end-of-transfer input mode the counter keeps counting down through zero to all ones with no terminal-count pulse, and `eot_in` high for an enabled channel clears its enable bit on the next edge.
- R9: A `desc_load` strobe loads `desc_dst` into the destination address of channel `desc_chan` only if its scatter/gather bit is set; in that mode software writes to the destination address are ignored, and with the bit clear the strobe is ignored.
- R10: A beat, write or descriptor load aimed at one channel leaves every other channel's registers unchanged.
- R11: A beat on a channel whose enable bit is clear changes neither its addresses nor its counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_chan | input | 2 | Channel written |
| wr_sel | input | 3 | Register selected for the write |
| wr_data | input | 32 | Write data |
| desc_load | input | 1 | Descriptor destination load strobe |
| desc_chan | input | 2 | Channel receiving the descriptor |
| desc_dst | input | 32 | Destination address from the descriptor |
| beat_done | input | 1 | A data beat completed |
| beat_chan | input | 2 | Channel of the completed beat |
| eot_in | input | 4 | External end-of-transfer, one per channel |
| src_addr | output | 128 | Source addresses, channel n in bits 32n+31:32n |
| dst_addr | output | 128 | Destination addresses, channel n in bits 32n+31:32n |
| count | output | 64 | Counters, channel n in bits 16n+15:16n |
| chan_en | output | 4 | Enable bit of each channel |
| chan_err | output | 4 | Error flag of each channel |
| tc_pulse | output | 4 | Terminal-count pulse of each channel |

## Verification
The bench drives the counter through 1 to 0 in terminal-count mode and through 0 to all ones in end-of-transfer input mode; a design that mixed the modes would either pulse and stop early or run on without ever halting. It pairs the decrement bit with each direction, so a design that decremented in memory-to-memory transfers or moved an unused address shows a wrong address. It places a word transfer on a misaligned destination, issues beats before and after re-aligning and after a clear with the wrong bit, which catches a flag that clears itself, a beat that slips through in the cycle the flag is set, or a clear that ignores the data bit. It also checks that descriptor loads and software destination writes swap roles with the scatter/gather bit.

// File: rtl/dmae_pkg.sv
package dmae_pkg;

    typedef enum logic [1:0] {
        W_BYTE = 2'd0,
        W_HALF = 2'd1,
        W_WORD = 2'd2,
        W_WRSV = 2'd3
    } xfer_width_e;

    typedef enum logic [1:0] {
        DIR_M2M  = 2'd0,
        DIR_M2P  = 2'd1,
        DIR_P2M  = 2'd2,
        DIR_RSV  = 2'd3
    } xfer_dir_e;

    typedef enum logic [2:0] {
        SEL_CTRL = 3'd0,
        SEL_SRC  = 3'd1,
        SEL_DST  = 3'd2,
        SEL_CNT  = 3'd3,
        SEL_STAT = 3'd4
    } reg_sel_e;

    typedef struct packed {
        logic        sg;
        logic        eot_mode;
        logic        dec;
        logic        dst_inc;
        logic        src_inc;
        xfer_dir_e   dir;
        xfer_width_e width;
        logic        en;
    } chan_ctrl_t;

    localparam int CTRL_W = $bits(chan_ctrl_t);

endpackage

// File: rtl/dmae_align_chk.sv
module dmae_align_chk
    import dmae_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr,
    input  xfer_width_e       width,
    output logic              misaligned
);
    always_comb begin
        unique case (width)
            W_BYTE:  misaligned = 1'b0;
            W_HALF:  misaligned = addr[0];
            default: misaligned = |addr[1:0];
        endcase
    end
endmodule

// File: rtl/dmae_addr_step.sv
module dmae_addr_step
    import dmae_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr,
    input  xfer_width_e       width,
    input  logic              inc,
    input  logic              down,
    output logic [ADDR_W-1:0] addr_next
);
    logic [ADDR_W-1:0] stride;

    always_comb begin
        unique case (width)
            W_BYTE:  stride = ADDR_W'(1);
            W_HALF:  stride = ADDR_W'(2);
            default: stride = ADDR_W'(4);
        endcase
        if (down)
            addr_next = addr - stride;
        else if (inc)
            addr_next = addr + stride;
        else
            addr_next = addr;
    end
endmodule

// File: rtl/dmae_channel.sv
module dmae_channel
    import dmae_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hit,
    input  logic [2:0]        wr_sel,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic              desc_hit,
    input  logic [ADDR_W-1:0] desc_dst,
    input  logic              beat,
    input  logic              eot,
    output logic [ADDR_W-1:0] src_o,
    output logic [ADDR_W-1:0] dst_o,
    output logic [CNT_W-1:0]  cnt_o,
    output logic              en_o,
    output logic              err_o,
    output logic              tc_o
);
    typedef struct packed {
        chan_ctrl_t          ctrl;
        logic [ADDR_W-1:0]   src;
        logic [ADDR_W-1:0]   dst;
        logic [CNT_W-1:0]    cnt;
        logic                err;
        logic                tc;
    } chan_state_t;

    chan_state_t s_q, s_d;

    logic              uses_src, uses_dst;
    logic              src_mis, dst_mis, misaligned;
    logic              go;
    logic [ADDR_W-1:0] src_next, dst_next;

    assign uses_src   = (s_q.ctrl.dir != DIR_P2M);
    assign uses_dst   = (s_q.ctrl.dir != DIR_M2P);
    assign misaligned = (uses_src & src_mis) | (uses_dst & dst_mis);
    assign go         = beat & s_q.ctrl.en & ~s_q.err & ~misaligned;

    dmae_align_chk #(.ADDR_W(ADDR_W)) u_src_chk (
        .addr       (s_q.src),
        .width      (s_q.ctrl.width),
        .misaligned (src_mis)
    );

    dmae_align_chk #(.ADDR_W(ADDR_W)) u_dst_chk (
        .addr       (s_q.dst),
        .width      (s_q.ctrl.width),
        .misaligned (dst_mis)
    );

    dmae_addr_step #(.ADDR_W(ADDR_W)) u_src_step (
        .addr      (s_q.src),
        .width     (s_q.ctrl.width),
        .inc       (s_q.ctrl.src_inc),
        .down      (s_q.ctrl.dec & (s_q.ctrl.dir == DIR_M2P)),
        .addr_next (src_next)
    );

    dmae_addr_step #(.ADDR_W(ADDR_W)) u_dst_step (
        .addr      (s_q.dst),
        .width     (s_q.ctrl.width),
        .inc       (s_q.ctrl.dst_inc),
        .down      (s_q.ctrl.dec & (s_q.ctrl.dir == DIR_P2M)),
        .addr_next (dst_next)
    );

    always_comb begin
        s_d    = s_q;
        s_d.tc = 1'b0;

        if (go) begin
            if (uses_src) s_d.src = src_next;
            if (uses_dst) s_d.dst = dst_next;
            s_d.cnt = s_q.cnt - CNT_W'(1);
            if (!s_q.ctrl.eot_mode && s_q.cnt == CNT_W'(1)) begin
                s_d.tc      = 1'b1;
                s_d.ctrl.en = 1'b0;
            end
        end

        if (s_q.ctrl.en && s_q.ctrl.eot_mode && eot)
            s_d.ctrl.en = 1'b0;

        if (s_q.ctrl.en && misaligned)
            s_d.err = 1'b1;

        if (wr_hit) begin
            unique case (wr_sel)
                SEL_CTRL: s_d.ctrl = chan_ctrl_t'(wr_data[CTRL_W-1:0]);
                SEL_SRC:  s_d.src  = wr_data;
                SEL_DST:  if (!s_q.ctrl.sg) s_d.dst = wr_data;
                SEL_CNT:  s_d.cnt  = wr_data[CNT_W-1:0];
                SEL_STAT: if (wr_data[0]) s_d.err = 1'b0;
                default:  ;
            endcase
        end

        if (desc_hit && s_q.ctrl.sg)
            s_d.dst = desc_dst;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            s_q <= '0;
        else
            s_q <= s_d;
    end

    assign src_o = s_q.src;
    assign dst_o = s_q.dst;
    assign cnt_o = s_q.cnt;
    assign en_o  = s_q.ctrl.en;
    assign err_o = s_q.err;
    assign tc_o  = s_q.tc;

    // R3: an enabled misaligned channel is flagged on the next edge
    a_r3_misalign_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ctrl.en && misaligned && !wr_hit) |=> s_q.err);

    // R4: a flagged channel keeps its counter and source address
    a_r4_error_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.err && !wr_hit) |=> ($stable(s_q.cnt) && $stable(s_q.src)));

    // R7: the terminal-count pulse lasts one cycle
    a_r7_tc_single: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.tc |=> !s_q.tc);

    // R8: an external end-of-transfer halts the channel
    a_r8_eot_halts: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ctrl.en && s_q.ctrl.eot_mode && eot && !wr_hit) |=> !s_q.ctrl.en);

    // R11: an idle channel keeps its counter
    a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.ctrl.en && !wr_hit) |=> $stable(s_q.cnt));

endmodule

// File: rtl/dma_addr_engine.sv
module dma_addr_engine
    import dmae_pkg::*;
#(
    parameter int N_CH   = 4,
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    localparam int CH_W  = (N_CH > 1) ? $clog2(N_CH) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [CH_W-1:0]          wr_chan,
    input  logic [2:0]               wr_sel,
    input  logic [ADDR_W-1:0]        wr_data,
    input  logic                     desc_load,
    input  logic [CH_W-1:0]          desc_chan,
    input  logic [ADDR_W-1:0]        desc_dst,
    input  logic                     beat_done,
    input  logic [CH_W-1:0]          beat_chan,
    input  logic [N_CH-1:0]          eot_in,
    output logic [N_CH*ADDR_W-1:0]   src_addr,
    output logic [N_CH*ADDR_W-1:0]   dst_addr,
    output logic [N_CH*CNT_W-1:0]    count,
    output logic [N_CH-1:0]          chan_en,
    output logic [N_CH-1:0]          chan_err,
    output logic [N_CH-1:0]          tc_pulse
);
    for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
        logic wr_hit, desc_hit, beat_hit;

        assign wr_hit   = wr_en     && (wr_chan   == CH_W'(ch));
        assign desc_hit = desc_load && (desc_chan == CH_W'(ch));
        assign beat_hit = beat_done && (beat_chan == CH_W'(ch));

        dmae_channel #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_hit   (wr_hit),
            .wr_sel   (wr_sel),
            .wr_data  (wr_data),
            .desc_hit (desc_hit),
            .desc_dst (desc_dst),
            .beat     (beat_hit),
            .eot      (eot_in[ch]),
            .src_o    (src_addr[ch*ADDR_W +: ADDR_W]),
            .dst_o    (dst_addr[ch*ADDR_W +: ADDR_W]),
            .cnt_o    (count[ch*CNT_W +: CNT_W]),
            .en_o     (chan_en[ch]),
            .err_o    (chan_err[ch]),
            .tc_o     (tc_pulse[ch])
        );
    end
endmodule

// File: tb/dma_addr_engine_test.sv
`timescale 1ns/1ps
module dma_addr_engine_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_chan = '0;
    logic [2:0]  wr_sel = '0;
    logic [31:0] wr_data = '0;
    logic        desc_load = 1'b0;
    logic [1:0]  desc_chan = '0;
    logic [31:0] desc_dst = '0;
    logic        beat_done = 1'b0;
    logic [1:0]  beat_chan = '0;
    logic [3:0]  eot_in = '0;
    logic [127:0] src_addr, dst_addr;
    logic [63:0]  count;
    logic [3:0]   chan_en, chan_err, tc_pulse;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    dma_addr_engine uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_chan(wr_chan),
        .wr_sel(wr_sel), .wr_data(wr_data), .desc_load(desc_load),
        .desc_chan(desc_chan), .desc_dst(desc_dst), .beat_done(beat_done),
        .beat_chan(beat_chan), .eot_in(eot_in), .src_addr(src_addr),
        .dst_addr(dst_addr), .count(count), .chan_en(chan_en),
        .chan_err(chan_err), .tc_pulse(tc_pulse)
    );

    function automatic logic [31:0] src(int ch); return src_addr[ch*32 +: 32]; endfunction
    function automatic logic [31:0] dst(int ch); return dst_addr[ch*32 +: 32]; endfunction
    function automatic logic [31:0] cnt(int ch); return {16'h0, count[ch*16 +: 16]}; endfunction

    function automatic logic [31:0] mk(bit en, int w, int dir, bit si, bit di,
                                       bit dec, bit eot, bit sg);
        return {22'h0, sg, eot, dec, di, si, dir[1:0], w[1:0], en};
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(int ch, int sel, logic [31:0] data);
        wr_en = 1'b1; wr_chan = ch[1:0]; wr_sel = sel[2:0]; wr_data = data;
        step();
        wr_en = 1'b0;
    endtask

    task automatic beat(int ch);
        beat_done = 1'b1; beat_chan = ch[1:0];
        step();
        beat_done = 1'b0;
    endtask

    task automatic desc(int ch, logic [31:0] a);
        desc_load = 1'b1; desc_chan = ch[1:0]; desc_dst = a;
        step();
        desc_load = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 src", src_addr[31:0] | src_addr[127:96], 32'h0);
        check("R1 dst", dst_addr[63:32] | dst_addr[95:64], 32'h0);
        check("R1 count", cnt(0) | cnt(3), 32'h0);
        check("R1 flags", {20'h0, chan_en, chan_err, tc_pulse}, 32'h0);
    endtask

    task automatic t_increment();
        wr(0, 1, 32'h100); wr(0, 2, 32'h200); wr(0, 3, 32'd3);
        wr(0, 0, mk(1, 2, 0, 1, 1, 0, 0, 0));
        check("R2 enable written", {31'h0, chan_en[0]}, 32'h1);
        beat(0);
        check("R5 word src inc", src(0), 32'h104);
        check("R5 word dst inc", dst(0), 32'h204);
        check("R7 count down", cnt(0), 32'd2);
        check("R10 other channel untouched", dst(1) | cnt(1), 32'h0);
        wr(1, 1, 32'h10); wr(1, 2, 32'h30); wr(1, 3, 32'd5);
        wr(1, 0, mk(1, 1, 1, 1, 1, 0, 0, 0));
        beat(1);
        check("R5 half src inc", src(1), 32'h12);
        check("R5 unused dst held", dst(1), 32'h30);
        check("R10 ch0 unchanged", src(0), 32'h104);
    endtask

    task automatic t_decrement();
        wr(2, 2, 32'h40); wr(2, 3, 32'd10);
        wr(2, 0, mk(1, 1, 2, 0, 1, 1, 0, 0));
        beat(2);
        check("R6 p2m dst dec", dst(2), 32'h3E);
        wr(2, 1, 32'h80); wr(2, 2, 32'h80);
        wr(2, 0, mk(1, 2, 0, 0, 1, 1, 0, 0));
        beat(2);
        check("R6 m2m dec ignored dst", dst(2), 32'h84);
        check("R6 m2m src no inc", src(2), 32'h80);
        wr(3, 1, 32'h21); wr(3, 3, 32'd10);
        wr(3, 0, mk(1, 0, 1, 1, 0, 1, 0, 0));
        beat(3);
        check("R6 m2p src dec", src(3), 32'h20);
        wr(3, 0, 32'h0);
    endtask

    task automatic t_terminal();
        wr(0, 3, 32'd2);
        wr(0, 0, mk(1, 2, 0, 1, 1, 0, 0, 0));
        beat(0);
        check("R7 count 1", cnt(0), 32'd1);
        check("R7 no pulse yet", {31'h0, tc_pulse[0]}, 32'h0);
        beat(0);
        check("R7 count 0", cnt(0), 32'd0);
        check("R7 pulse", {31'h0, tc_pulse[0]}, 32'h1);
        check("R7 enable cleared", {31'h0, chan_en[0]}, 32'h0);
        step();
        check("R7 pulse one cycle", {31'h0, tc_pulse[0]}, 32'h0);
        beat(0);
        check("R11 disabled count", cnt(0), 32'd0);
        check("R11 disabled dst", dst(0), 32'h20C);
    endtask

    task automatic t_eot();
        wr(1, 3, 32'd1);
        wr(1, 0, mk(1, 1, 1, 1, 0, 0, 1, 0));
        beat(1);
        check("R8 count 0", cnt(1), 32'd0);
        check("R8 no pulse", {31'h0, tc_pulse[1]}, 32'h0);
        beat(1);
        check("R8 wrap", cnt(1), 32'hFFFF);
        check("R8 still enabled", {31'h0, chan_en[1]}, 32'h1);
        eot_in[1] = 1'b1;
        step();
        eot_in[1] = 1'b0;
        check("R8 eot halts", {31'h0, chan_en[1]}, 32'h0);
    endtask

    task automatic t_align();
        wr(2, 0, 32'h0);
        wr(2, 2, 32'h202); wr(2, 3, 32'd5);
        wr(2, 0, mk(1, 2, 2, 0, 1, 0, 0, 0));
        beat(2);
        check("R3 error set", {31'h0, chan_err[2]}, 32'h1);
        check("R3 blocked dst", dst(2), 32'h202);
        check("R3 blocked count", cnt(2), 32'd5);
        wr(2, 2, 32'h200);
        beat(2);
        check("R4 error holds", {31'h0, chan_err[2]}, 32'h1);
        check("R4 beat ignored", dst(2), 32'h200);
        wr(2, 4, 32'h0);
        check("R4 clear needs bit0", {31'h0, chan_err[2]}, 32'h1);
        wr(2, 4, 32'h1);
        check("R4 cleared", {31'h0, chan_err[2]}, 32'h0);
        beat(2);
        check("R4 resumes dst", dst(2), 32'h204);
        check("R4 resumes count", cnt(2), 32'd4);
    endtask

    task automatic t_scatter();
        wr(3, 0, mk(0, 0, 0, 0, 0, 0, 0, 1));
        desc(3, 32'h800);
        check("R9 descriptor load", dst(3), 32'h800);
        check("R10 ch2 dst kept", dst(2), 32'h204);
        wr(3, 2, 32'h900);
        check("R9 software dst ignored", dst(3), 32'h800);
        wr(3, 0, 32'h0);
        desc(3, 32'hA00);
        check("R9 descriptor ignored", dst(3), 32'h800);
        wr(3, 2, 32'h900);
        check("R2 dst write", dst(3), 32'h900);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_increment();
        t_decrement();
        t_terminal();
        t_eot();
        t_align();
        t_scatter();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        #1000000;
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule